// File: doc/BRIEF.md
# Serial Control Register Loader

This block receives control words from a host over a three-wire serial link and places each word in one of two control registers. The host raises an enable line to claim the port. It presents each bit on a data line and changes it while the serial clock is low. The block takes the bit when the serial clock rises. A rising edge on a latch strobe then commits the last twelve bits received.

The first bit of those twelve acts as a one-bit register address. A low address bit sends the other eleven bits to an attenuation register. A high address bit sends the low seven bits to a mode-flag register, but only if the four bits between the address and the flags are all zero.

All four host lines are asynchronous to the system clock and pass through multi-stage synchronisers. Edges are found by comparing the current synchronised sample with the previous one. Each successful write is reported by a one-cycle pulse on the update output of the register that was written.

Top module: `sctl_loader`

## Requirements
- R1: After reset, `att_o` is 0, `mode_o` is 0, both update pulses are low, and the internal 12-bit frame register holds 0.
- R2: Each rising edge of `sclk_i` while enabled shifts `sdat_i` into the frame. The first bit sent becomes frame bit 11, the address bit, and the last bit becomes frame bit 0.
- R3: On a rising edge of `strb_i` with frame bit 11 low, `att_o` takes frame bits 10..0. Frame bit 10 is the attenuation MSB.
- R4: On a rising edge of `strb_i` with frame bit 11 high and frame bits 10..7 all zero, `mode_o` takes frame bits 6..0. The bit map is: mode[6] test flag 1, mode[5] test flag 2, mode[4] rate flag, mode[3] 12 dB flag, mode[2] input-rate select 1, mode[1] input-rate select 2, mode[0] de-emphasis.
- R5: A mode frame with any of frame bits 10..7 set is discarded. Both registers keep their values and no update pulse occurs.
- R6: When more than 12 bits arrive before a strobe, only the last 12 are used.
- R7: When fewer than 12 bits arrive, the frame is the earlier contents shifted left by the new bits.
- R8: While `en_i` is low, serial clock edges do not shift the frame and strobe edges do not write any register.
- R9: Each successful write raises the update output of the written register for exactly one system clock cycle. The two update outputs are never high together.
- R10: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Port enable from the host (asynchronous) |
| sdat_i | input | 1 | Serial data (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| strb_i | input | 1 | Latch strobe (asynchronous) |
| att_o | output | 11 | Attenuation register |
| mode_o | output | 7 | Mode-flag register |
| att_upd_o | output | 1 | One-cycle pulse when the attenuation register is written |
| mode_upd_o | output | 1 | One-cycle pulse when the mode register is written |

## Verification
The hardest condition to reach from the ports is a disabled port that leaves the hidden frame register untouched. The frame register has no output of its own. The stimulus first shifts a full frame while disabled, then re-enables the port and issues a strobe with no new bits. The attenuation value that results shows whether the disabled bits leaked in. A short frame after a known full frame shows the stale-bit merge in the same way.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   localparam int unsigned FRAME_W = 12;
   localparam int unsigned ATT_W   = 11;
   localparam int unsigned MODE_W  = 7;
   localparam int unsigned RSV_W   = 4;

   typedef enum logic {
      DEST_ATT  = 1'b0,
      DEST_MODE = 1'b1
   } dest_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sctl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else begin
               if (s == 0) stage_q[s] <= d_i;
               else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sctl_edge.sv
module sctl_edge #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl_i;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_rise
         assign rise_o[i] = lvl_i[i] & ~prev_q[i];
      end
   endgenerate
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
   parameter int unsigned FRAME_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_i,
   input  logic               bit_i,
   output logic [FRAME_W-1:0] frame_o
);
   logic [FRAME_W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (shift_i) sr_q <= {sr_q[FRAME_W-2:0], bit_i};
   end

   assign frame_o = sr_q;
endmodule

// File: rtl/sctl_route.sv
module sctl_route
   import sctl_pkg::*;
#(
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned ATT_W   = 11,
   parameter int unsigned MODE_W  = 7,
   parameter int unsigned RSV_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               latch_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic [ATT_W-1:0]   att_o,
   output logic [MODE_W-1:0]  mode_o,
   output logic               att_upd_o,
   output logic               mode_upd_o
);
   localparam int unsigned ADDR_BIT = FRAME_W - 1;
   localparam int unsigned RSV_LO   = MODE_W;

   dest_e dest;
   logic  rsv_ok;

   assign dest = dest_e'(frame_i[ADDR_BIT]);

   generate
      if (RSV_W > 0) begin : g_rsv_chk
         assign rsv_ok = (frame_i[RSV_LO +: RSV_W] == '0);
      end else begin : g_rsv_none
         assign rsv_ok = 1'b1;
      end
   endgenerate

   logic wr_att, wr_mode;
   assign wr_att  = latch_i && (dest == DEST_ATT);
   assign wr_mode = latch_i && (dest == DEST_MODE) && rsv_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         att_o      <= '0;
         mode_o     <= '0;
         att_upd_o  <= 1'b0;
         mode_upd_o <= 1'b0;
      end else begin
         att_upd_o  <= wr_att;
         mode_upd_o <= wr_mode;
         if (wr_att)  att_o  <= frame_i[ATT_W-1:0];
         if (wr_mode) mode_o <= frame_i[MODE_W-1:0];
      end
   end
endmodule

// File: rtl/sctl_loader.sv
module sctl_loader
   import sctl_pkg::*;
#(
   parameter int unsigned FRAME_W     = sctl_pkg::FRAME_W,
   parameter int unsigned ATT_W       = sctl_pkg::ATT_W,
   parameter int unsigned MODE_W      = sctl_pkg::MODE_W,
   parameter int unsigned RSV_W       = sctl_pkg::RSV_W,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              sdat_i,
   input  logic              sclk_i,
   input  logic              strb_i,
   output logic [ATT_W-1:0]  att_o,
   output logic [MODE_W-1:0] mode_o,
   output logic              att_upd_o,
   output logic              mode_upd_o
);
   localparam int unsigned N_LINES = 4;
   localparam int unsigned N_EDGES = 2;

   generate
      if (FRAME_W != ATT_W + 1) begin : g_bad_att
         $error("sctl_loader: FRAME_W must equal ATT_W + 1");
      end
      if (FRAME_W != 1 + RSV_W + MODE_W) begin : g_bad_mode
         $error("sctl_loader: FRAME_W must equal 1 + RSV_W + MODE_W");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines, sync_lines;
   logic               en_s, dat_s, sclk_s, strb_s;
   logic [N_EDGES-1:0] rise;
   logic               sclk_rise, strb_rise;
   logic [FRAME_W-1:0] frame_q;

   assign raw_lines = {en_i, sdat_i, sclk_i, strb_i};

   sctl_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   assign {en_s, dat_s, sclk_s, strb_s} = sync_lines;

   sctl_edge #(.W(N_EDGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({sclk_s, strb_s}),
      .rise_o (rise)
   );

   assign {sclk_rise, strb_rise} = rise;

   sctl_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (sclk_rise & en_s),
      .bit_i   (dat_s),
      .frame_o (frame_q)
   );

   sctl_route #(
      .FRAME_W (FRAME_W),
      .ATT_W   (ATT_W),
      .MODE_W  (MODE_W),
      .RSV_W   (RSV_W)
   ) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .latch_i    (strb_rise & en_s),
      .frame_i    (frame_q),
      .att_o      (att_o),
      .mode_o     (mode_o),
      .att_upd_o  (att_upd_o),
      .mode_upd_o (mode_upd_o)
   );
endmodule

// File: rtl/sctl_loader_chk.sv
module sctl_loader_chk #(
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned ATT_W   = 11,
   parameter int unsigned MODE_W  = 7,
   parameter int unsigned RSV_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_s,
   input logic [FRAME_W-1:0] frame_q,
   input logic [ATT_W-1:0]   att_o,
   input logic [MODE_W-1:0]  mode_o,
   input logic               att_upd_o,
   input logic               mode_upd_o
);
   // R1: while held in reset the outputs sit at their cleared values
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (att_o == '0 && mode_o == '0 && !att_upd_o && !mode_upd_o));

   // R9: pulses last one cycle and never coincide
   a_r9_att_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      att_upd_o |=> !att_upd_o);
   a_r9_mode_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      mode_upd_o |=> !mode_upd_o);
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(att_upd_o && mode_upd_o));

   // R3 / R10: attenuation value moves only with its pulse
   a_r3_att_changes_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (att_o != $past(att_o)) |-> att_upd_o);

   // R4 / R10: mode value moves only with its pulse
   a_r4_mode_changes_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> mode_upd_o);

   // R5: a mode write only follows a frame with clear reserved bits
   a_r5_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
      mode_upd_o |-> ($past(frame_q[MODE_W +: RSV_W]) == '0));

   // R8: no write without the synchronised enable
   a_r8_att_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      att_upd_o |-> $past(en_s));
   a_r8_mode_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      mode_upd_o |-> $past(en_s));
endmodule

bind sctl_loader sctl_loader_chk #(
   .FRAME_W (FRAME_W),
   .ATT_W   (ATT_W),
   .MODE_W  (MODE_W),
   .RSV_W   (RSV_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en_s       (en_s),
   .frame_q    (frame_q),
   .att_o      (att_o),
   .mode_o     (mode_o),
   .att_upd_o  (att_upd_o),
   .mode_upd_o (mode_upd_o)
);

// File: tb/sctl_loader_tb.sv
`timescale 1ns/1ps
module sctl_loader_tb;
   localparam int HOLD = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0, sdat_i = 1'b0, sclk_i = 1'b0, strb_i = 1'b0;
   logic [10:0] att_o;
   logic [6:0]  mode_o;
   logic        att_upd_o, mode_upd_o;

   int n_chk = 0, n_fail = 0;
   int att_pulses = 0, mode_pulses = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sctl_loader u_dut (
      .clk (clk), .rst_n (rst_n), .en_i (en_i), .sdat_i (sdat_i),
      .sclk_i (sclk_i), .strb_i (strb_i), .att_o (att_o), .mode_o (mode_o),
      .att_upd_o (att_upd_o), .mode_upd_o (mode_upd_o)
   );

   always @(posedge clk) begin
      if (att_upd_o)  att_pulses++;
      if (mode_upd_o) mode_pulses++;
   end

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_clks(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      sclk_i = 1'b0; sdat_i = b; wait_clks(HOLD);
      sclk_i = 1'b1;             wait_clks(HOLD);
      sclk_i = 1'b0;
   endtask

   task automatic send_bits(logic [15:0] v, int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic strobe();
      strb_i = 1'b1; wait_clks(HOLD);
      strb_i = 1'b0; wait_clks(HOLD);
   endtask

   task automatic clear_counts();
      att_pulses = 0; mode_pulses = 0;
   endtask

   task automatic t_reset();
      check("R1 att", att_o, 0);
      check("R1 mode", mode_o, 0);
      check("R1 pulses", att_upd_o + mode_upd_o, 0);
   endtask

   task automatic t_att(logic [11:0] f, string req);
      clear_counts();
      send_bits(16'(f), 12); strobe();
      check({req, " att"}, att_o, f[10:0]);
      check("R9 att pulse count", att_pulses, 1);
      check("R9 no mode pulse", mode_pulses, 0);
   endtask

   task automatic t_mode(logic [6:0] m, logic [10:0] att_keep);
      clear_counts();
      send_bits({4'h0, 1'b1, 4'b0000, m}, 12); strobe();
      check("R4 mode", mode_o, m);
      check("R10 att kept", att_o, att_keep);
      check("R9 mode pulse count", mode_pulses, 1);
      check("R9 no att pulse", att_pulses, 0);
   endtask

   task automatic t_reserved(logic [6:0] m_keep, logic [10:0] att_keep);
      clear_counts();
      send_bits(16'hA0F, 12); strobe();
      check("R5 mode kept", mode_o, m_keep);
      check("R5 att kept", att_o, att_keep);
      check("R5 no pulses", att_pulses + mode_pulses, 0);
   endtask

   task automatic t_overlong();
      clear_counts();
      send_bits(16'hF123, 16); strobe();
      check("R6 last 12 bits", att_o, 11'h123);
      check("R6 pulse", att_pulses, 1);
   endtask

   task automatic t_short();
      clear_counts();
      send_bits(16'hA, 4); strobe();
      check("R7 stale merge", att_o, 11'h23A);
   endtask

   task automatic t_disabled();
      clear_counts();
      en_i = 1'b0; wait_clks(HOLD);
      send_bits(16'h0F0, 12); strobe();
      check("R8 att held", att_o, 11'h23A);
      check("R8 no pulses", att_pulses + mode_pulses, 0);
      en_i = 1'b1; wait_clks(HOLD);
      strobe();
      check("R8 frame not shifted", att_o, 11'h23A);
      check("R8 strobe after enable", att_pulses, 1);
   endtask

   initial begin
      wait_clks(3);
      t_reset();
      rst_n = 1'b1; wait_clks(2);
      en_i = 1'b1; wait_clks(HOLD);
      t_att(12'h59A, "R2 R3");
      t_att(12'h7FF, "R3 all ones");
      t_mode(7'b1010011, 11'h7FF);
      t_reserved(7'b1010011, 11'h7FF);
      t_mode(7'b0101100, 11'h7FF);
      t_overlong();
      t_short();
      t_disabled();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule